// File: doc/BRIEF.md
# Two-Stage Cascaded Folded FIR Filter

An eight-tap unsigned FIR filter built from two time-shared multiply-accumulate stages of four taps each. Each stage owns one multiplier and one accumulator, and steps through its four taps over four clocks, so a new sample is taken and a new result is produced every four clocks. That is twice the rate of a single fully folded eight-tap filter, at the cost of a second multiplier. The first stage handles taps 0 to 3, and the second stage handles taps 4 to 7.

The two stages overlap in time. While the first stage finishes the result for the newest sample, the second stage computes the upper-tap partial sum for the next sample. That partial sum is registered at the sample boundary. It then becomes the starting value of the first stage's accumulator in the following period. Samples reach the second stage by moving along from the first stage's sample window.

Coefficients are shifted in serially while a load select is held high. Holding that select high also restarts the filter with an empty sample history.

Top module: `fir2_cascade_top`

## Requirements
- R1: Every result equals the unsigned sum over k = 0..7 of h_k times x(n-k), where x(n) is the sample the result belongs to. Samples from before the last restart count as zero. The 19-bit output never wraps, including the case of all samples and all coefficients at 255.
- R2: Once reset is released or `coef_load` falls, `x_in` is captured on the 4th rising edge, and then on every 4th rising edge after that.
- R3: The result for a sample captured on edge E is presented on `y_out` after edge E+4. It stays unchanged until the next sample-period boundary. The first result after a restart therefore appears after the 8th edge.
- R4: `y_valid` is high for exactly one cycle in every four clocks, in the cycle that the new result appears. It stays low during the first sample period after a restart.
- R5: While `coef_load` is high, each rising edge shifts `coef_in` into the coefficient store. After eight such edges, the first value shifted in acts as h0 and the last value acts as h7.
- R6: A cycle with `coef_load` high clears the sample history of both stages, the held partial sum, `y_out` and `y_valid`. It also holds the period counter at its start, so periods restart when `coef_load` falls.
- R7: While `rst_n` is low, `y_out` is zero and `y_valid` is low.
- R8: With coefficients loaded, a single sample of value 1 followed by zeros yields h0 through h7 on eight consecutive strobes, then zeros. Taps 4 to 7 reach the output only through the second stage's partial sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| x_in | input | DATA_W (8) | Unsigned sample, captured on the period boundary edge |
| coef_in | input | COEF_W (8) | Unsigned coefficient, shifted in while coef_load is high |
| coef_load | input | 1 | Coefficient shift enable; also restarts the filter |
| y_out | output | OUT_W (19) | Filter result, held for one sample period |
| y_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
A restart is counted from the falling edge of `coef_load`. Sample k is captured on edge 4(k+1) after that point, and its result and strobe appear after edge 4(k+2). The bench therefore changes `x_in` in the low phase before each capture edge. It also pushes the convolution value it expects into a queue at that moment. A monitor reads the outputs on every falling clock edge and pops one expected value per strobe. It checks that the first strobe comes eight rising edges after the restart and that later strobes are exactly four edges apart. Any strobe that arrives with no result pending is counted as a failure.

// File: rtl/fir2_pkg.sv
package fir2_pkg;

  // Width that holds a sum of n unsigned products of dw x cw bits without wrap.
  function automatic int sum_width(input int dw, input int cw, input int n);
    return dw + cw + $clog2(n);
  endfunction

endpackage

// File: rtl/fir2_phase_seq.sv
module fir2_phase_seq #(
  parameter int TAPS = 4,
  localparam int PH_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            coef_load,
  output logic [PH_W-1:0] phase,
  output logic            first,
  output logic            period_end,
  output logic            valid
);

  localparam logic [PH_W-1:0] LAST = PH_W'(TAPS - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            primed_q, primed_d;
  logic            valid_q, valid_d;
  logic            bound;

  always_comb begin
    bound    = !coef_load && (phase_q == LAST);
    phase_d  = (coef_load || bound) ? '0 : phase_q + PH_W'(1);
    primed_d = primed_q;
    if (coef_load)  primed_d = 1'b0;
    else if (bound) primed_d = 1'b1;
    valid_d  = bound && primed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      primed_q <= primed_d;
      valid_q  <= valid_d;
    end
  end

  assign phase      = phase_q;
  assign first      = (phase_q == '0);
  assign period_end = bound;
  assign valid      = valid_q;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  a_r4_pulse_after_last_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(phase_q == LAST));

  a_r6_load_quiets_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    coef_load |=> !valid_q);

  a_r6_load_restarts_phase: assert property (@(posedge clk) disable iff (!rst_n)
    coef_load |=> (phase_q == '0));

endmodule

// File: rtl/fir2_tap_store.sv
module fir2_tap_store #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 4,
  parameter int STAGES = 2,
  localparam int PH_W  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           coef_load,
  input  logic [COEF_W-1:0]              coef_in,
  input  logic [DATA_W-1:0]              x_in,
  input  logic                           capture,
  input  logic [PH_W-1:0]                phase,
  output logic [STAGES-1:0][COEF_W-1:0]  coef_sel,
  output logic [STAGES-1:0][DATA_W-1:0]  data_sel
);

  localparam int NCOEF = TAPS * STAGES;
  localparam int CI_W  = (NCOEF > 1) ? $clog2(NCOEF) : 1;

  // Coefficient store: index j holds tap h_j once loading completes.
  logic [NCOEF-1:0][COEF_W-1:0] coef_q, coef_d;
  logic                         coef_en;

  // Sample windows: win_q[s][t] is the sample t periods older than stage s's newest.
  logic [STAGES-1:0][TAPS-1:0][DATA_W-1:0] win_q, win_d;
  logic                                    win_en;

  always_comb begin
    coef_en = coef_load;
    for (int j = 0; j < NCOEF - 1; j++) coef_d[j] = coef_q[j+1];
    coef_d[NCOEF-1] = coef_in;
  end

  always_comb begin
    win_en = coef_load || capture;
    win_d  = '0;
    if (!coef_load) begin
      win_d[0][0] = x_in;
      for (int s = 1; s < STAGES; s++) win_d[s][0] = win_q[s-1][TAPS-2];
      for (int s = 0; s < STAGES; s++)
        for (int t = 1; t < TAPS; t++) win_d[s][t] = win_q[s][t-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       coef_q <= '0;
    else if (coef_en) coef_q <= coef_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_sel
    assign coef_sel[s] = coef_q[CI_W'(s * TAPS) + CI_W'(phase)];
    assign data_sel[s] = win_q[s][phase];
  end

  a_r5_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_load |=> $stable(coef_q));

  a_r2_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!coef_load && !capture) |=> $stable(win_q));

  a_r6_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
    coef_load |=> (win_q == '0));

endmodule

// File: rtl/fir2_mac.sv
module fir2_mac #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              first,
  input  logic [COEF_W-1:0] coef,
  input  logic [DATA_W-1:0] data,
  input  logic [OUT_W-1:0]  seed,
  output logic [OUT_W-1:0]  sum_nxt
);

  localparam int PROD_W = DATA_W + COEF_W;

  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  base;
  logic [OUT_W-1:0]  acc_q, acc_d;
  logic              acc_en;

  always_comb begin
    prod    = coef * data;
    base    = first ? seed : acc_q;
    sum_nxt = base + OUT_W'(prod);
    acc_en  = 1'b1;
    acc_d   = clr ? '0 : sum_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !first) |-> (sum_nxt >= acc_q));

endmodule

// File: rtl/fir2_cascade_top.sv
module fir2_cascade_top
  import fir2_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 4,
  parameter int STAGES = 2,
  parameter int OUT_W  = sum_width(DATA_W, COEF_W, TAPS * STAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] x_in,
  input  logic [COEF_W-1:0] coef_in,
  input  logic              coef_load,
  output logic [OUT_W-1:0]  y_out,
  output logic              y_valid
);

  localparam int PH_W = (TAPS > 1) ? $clog2(TAPS) : 1;

  logic [PH_W-1:0]                 phase;
  logic                            first;
  logic                            period_end;
  logic [STAGES-1:0][COEF_W-1:0]   coef_sel;
  logic [STAGES-1:0][DATA_W-1:0]   data_sel;
  logic [STAGES-1:0][OUT_W-1:0]    seed;
  logic [STAGES-1:0][OUT_W-1:0]    sum_nxt;
  // res_q[0] is the filter output; res_q[s>0] is the partial sum seeding stage s-1.
  logic [STAGES-1:0][OUT_W-1:0]    res_q, res_d;
  logic                            res_en;

  fir2_phase_seq #(.TAPS(TAPS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_load  (coef_load),
    .phase      (phase),
    .first      (first),
    .period_end (period_end),
    .valid      (y_valid)
  );

  fir2_tap_store #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .TAPS   (TAPS),
    .STAGES (STAGES)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .coef_load (coef_load),
    .coef_in   (coef_in),
    .x_in      (x_in),
    .capture   (period_end),
    .phase     (phase),
    .coef_sel  (coef_sel),
    .data_sel  (data_sel)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == STAGES - 1) begin : g_tail
      assign seed[s] = '0;
    end else begin : g_link
      assign seed[s] = res_q[s+1];
    end

    fir2_mac #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .OUT_W  (OUT_W)
    ) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (coef_load),
      .first   (first),
      .coef    (coef_sel[s]),
      .data    (data_sel[s]),
      .seed    (seed[s]),
      .sum_nxt (sum_nxt[s])
    );
  end

  always_comb begin
    res_en = coef_load || period_end;
    res_d  = coef_load ? '0 : sum_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign y_out = res_q[0];

  a_r3_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!coef_load && !period_end) |=> $stable(y_out));

  a_r3_strobe_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> $past(period_end));

endmodule

// File: tb/fir2_cascade_top_tb.sv
`timescale 1ns/1ps
module fir2_cascade_top_tb;

  localparam int DW = 8;
  localparam int CW = 8;
  localparam int NT = 8;
  localparam int OW = 19;
  localparam realtime HALF = 2.0ns;
  localparam int MAX_CYC = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] x_in = '0;
  logic [CW-1:0] coef_in = '0;
  logic          coef_load = 1'b1;
  logic [OW-1:0] y_out;
  logic          y_valid;

  fir2_cascade_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_in      (x_in),
    .coef_in   (coef_in),
    .coef_load (coef_load),
    .y_out     (y_out),
    .y_valid   (y_valid)
  );

  always #(HALF) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  int    start_cyc = 0;
  int    last_strobe = -1;
  bit    first_pending = 1'b0;
  string tag = "R1";

  longint unsigned exp_q[$];
  int unsigned     h[NT];
  int unsigned     hist[NT];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  // Scoreboard monitor: outputs are read on falling edges.
  always @(negedge clk) begin
    if (rst_n && y_valid) begin
      if (first_pending) begin
        check(cyc - start_cyc == 8, "R2 R3 first result edge", cyc - start_cyc, 8);
        first_pending = 1'b0;
      end else if (last_strobe >= 0) begin
        check(cyc - last_strobe == 4, "R4 strobe spacing", cyc - last_strobe, 4);
      end
      last_strobe = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 strobe with nothing pending", y_out, 0);
      end else begin
        longint unsigned e;
        e = exp_q.pop_front();
        check(longint'(y_out) == longint'(e), tag, y_out, e);
      end
    end
  end

  // R5 R6: shift coefficients h0..h7 and restart with empty history.
  task automatic load_coefs();
    coef_load = 1'b1;
    for (int j = 0; j < NT; j++) begin
      coef_in = CW'(h[j]);
      @(negedge clk);
    end
    coef_load = 1'b0;
    for (int j = 0; j < NT; j++) hist[j] = 0;
    start_cyc     = cyc;
    first_pending = 1'b1;
    last_strobe   = -1;
  endtask

  // mode 0: impulse, 1: random, 2: all ones at full scale
  task automatic stream(input int count, input int mode);
    for (int k = 0; k < count; k++) begin
      int unsigned v;
      longint unsigned acc;
      repeat (3) @(negedge clk);
      case (mode)
        0:       v = (k == 0) ? 1 : 0;
        1:       v = $urandom_range(0, 255);
        default: v = 255;
      endcase
      x_in = DW'(v);
      for (int j = NT - 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = v;
      acc = 0;
      for (int j = 0; j < NT; j++) acc += longint'(h[j]) * longint'(hist[j]);
      exp_q.push_back(acc);
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(HALF * 2 * MAX_CYC);
    check(1'b0, "R2 watchdog", MAX_CYC, 0);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(y_out == '0, "R7 reset y_out", y_out, 0);
    check(y_valid == 1'b0, "R7 reset y_valid", y_valid, 0);
    rst_n = 1'b1;

    // R5 R8: impulse reveals coefficient order through both stages
    for (int j = 0; j < NT; j++) h[j] = j + 1;
    load_coefs();
    tag = "R5 R8 impulse";
    stream(14, 0);

    // R1: random coefficients and samples
    for (int j = 0; j < NT; j++) h[j] = $urandom_range(0, 255);
    load_coefs();
    tag = "R1 random";
    stream(40, 1);

    // R1: full scale, largest sum without wrap
    for (int j = 0; j < NT; j++) h[j] = 255;
    load_coefs();
    tag = "R1 full scale";
    stream(12, 2);

    // R6: reload after a full-scale run must start from an empty history
    for (int j = 0; j < NT; j++) h[j] = $urandom_range(1, 255);
    load_coefs();
    tag = "R6 R1 after reload";
    stream(20, 1);

    coef_load = 1'b1;
    @(negedge clk);
    check(exp_q.size() == 0, "R3 results outstanding", exp_q.size(), 0);
    @(negedge clk);
    check(y_valid == 1'b0, "R6 strobe during load", y_valid, 0);
    report();
    $finish;
  end

endmodule